// File: doc/BRIEF.md
# Sleep State Output Controller

This block keeps the current system power state (S0, S1, S3, S4 or S5) and decodes it into a set of active-low rail-switch outputs, a deep-sleep indicator, a suspend status line and a clock-generator power-good. The rail outputs cover nested groups of states, so the deeper a state is, the more rails are off. Software asks for a sleep state through a simple request port. The block accepts a request only while the system runs in S0.

Wake events bring the system back to S0 from any sleeping state. A weak battery blocks wake from the deep states, but not from S1. An over-temperature trip or a forced-off request moves the system straight to S5, with no handshake and above every other source. The asynchronous inputs (wake, trip, forced-off, battery) pass through a synchronizer whose depth is a parameter.

Top module: `sleep_state_ctrl`

## Requirements
- R1: `rail_main_n` is low when `sys_state` is S3, S4 or S5 and high in S0 and S1. State codes on `sys_state` and `tgt_state` are S0=0, S1=1, S3=3, S4=4, S5=5.
- R2: `rail_mem_n` is low when the state is S4 or S5 and high otherwise.
- R3: `rail_aux_n` is low only in S5.
- R4: `deep_ind_n` is low whenever the state is S4 or S5.
- R5: When `overtemp_n` is held low, the state becomes S5 no later than SYNC_STAGES+1 cycles later, from any state. This holds even if a wake or a request arrives in the same cycle.
- R6: `force_off` held high moves any state to S5 in the same way and with the same priority as R5.
- R7: With `fw_present` low, `rail_mgmt_n` equals `rail_main_n`. With `fw_present` high, `rail_mgmt_n` stays high.
- R8: While `batt_weak` is high, a wake leaves S3, S4 and S5 unchanged. A wake from S1 is still honoured.
- R9: `clkgen_pg` is high only when `rail_main_n` and `vreg_good` are both high.
- R10: After a request is accepted, `suspending_n` goes low on the next clock edge, one edge before the state changes. It stays low in every state other than S0 and returns high on the edge that restores S0.
- R11: A wake event in S1, S3, S4 or S5 returns the state to S0.
- R12: A request is accepted only in S0 and only for codes 1, 3, 4 and 5. Any other code, and any request made outside S0, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tgt_valid | input | 1 | Sleep request strobe |
| tgt_state | input | 3 | Requested state code |
| wake_req | input | 1 | Wake event (asynchronous) |
| overtemp_n | input | 1 | Thermal trip, active low (asynchronous) |
| force_off | input | 1 | Forced soft-off request (asynchronous) |
| batt_weak | input | 1 | Battery too weak to wake (asynchronous) |
| vreg_good | input | 1 | Processor regulator good |
| fw_present | input | 1 | Management firmware present strap |
| sys_state | output | 3 | Current state code |
| rail_main_n | output | 1 | Main rails off, low in S3/S4/S5 |
| rail_mem_n | output | 1 | Memory rails off, low in S4/S5 |
| rail_aux_n | output | 1 | Remaining rails off, low in S5 |
| rail_mgmt_n | output | 1 | Management subsystem rail control |
| deep_ind_n | output | 1 | Deep-sleep indicator, low in S4/S5 |
| suspending_n | output | 1 | Suspend status, low while entering or in sleep |
| clkgen_pg | output | 1 | Clock-generator power-good |

## Verification
A thermal trip can fall in the same cycle as a wake event, and so can a forced-off request. The bench sleeps the system in S3, then drops `overtemp_n` on the same edge that raises `wake_req`. It expects S5 with every rail low rather than a return to S0. It then holds the trip while further wakes arrive and checks that the state stays in S5. A forced-off from S1 is judged the same way, and after each release a plain wake must bring S0 back.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
   typedef enum logic [2:0] {
      ST_S0 = 3'd0,
      ST_S1 = 3'd1,
      ST_S3 = 3'd3,
      ST_S4 = 3'd4,
      ST_S5 = 3'd5
   } acpi_st_e;

   localparam int unsigned ST_W = 3;

   function automatic logic legal_target(input logic [ST_W-1:0] code);
      return (code == ST_S1) || (code == ST_S3) || (code == ST_S4) || (code == ST_S5);
   endfunction

   function automatic logic is_deep(input logic [ST_W-1:0] code);
      return (code == ST_S3) || (code == ST_S4) || (code == ST_S5);
   endfunction
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sleep_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
   import sleep_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tgt_valid,
   input  logic [ST_W-1:0] tgt_state,
   input  logic            wake_s,
   input  logic            kill_s,
   input  logic            batt_s,
   output logic [ST_W-1:0] state_q,
   output logic            susp_n_q
);
   logic [ST_W-1:0] pend_q;
   logic            pend_v_q;
   logic            wake_ok;
   logic            take_req;

   always_comb begin
      wake_ok  = wake_s && (state_q != ST_S0) && !(batt_s && is_deep(state_q));
      take_req = tgt_valid && (state_q == ST_S0) && !pend_v_q && legal_target(tgt_state);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_S0;
         pend_q   <= ST_S0;
         pend_v_q <= 1'b0;
         susp_n_q <= 1'b1;
      end else if (kill_s) begin
         state_q  <= ST_S5;
         pend_v_q <= 1'b0;
         susp_n_q <= 1'b0;
      end else if (pend_v_q) begin
         state_q  <= pend_q;
         pend_v_q <= 1'b0;
      end else if (wake_ok) begin
         state_q  <= ST_S0;
         susp_n_q <= 1'b1;
      end else if (take_req) begin
         pend_q   <= tgt_state;
         pend_v_q <= 1'b1;
         susp_n_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sleep_decode.sv
module sleep_decode
   import sleep_pkg::*;
#(
   parameter bit HAS_MGMT = 1'b1
) (
   input  logic [ST_W-1:0] state_q,
   input  logic            fw_present,
   input  logic            vreg_good,
   output logic            rail_main_n,
   output logic            rail_mem_n,
   output logic            rail_aux_n,
   output logic            rail_mgmt_n,
   output logic            deep_ind_n,
   output logic            clkgen_pg
);
   logic s4_grp;

   always_comb begin
      s4_grp      = (state_q == ST_S4) || (state_q == ST_S5);
      rail_main_n = !is_deep(state_q);
      rail_mem_n  = !s4_grp;
      rail_aux_n  = (state_q != ST_S5);
      deep_ind_n  = !s4_grp;
      clkgen_pg   = rail_main_n && vreg_good;
   end

   generate
      if (HAS_MGMT) begin : g_mgmt
         assign rail_mgmt_n = fw_present ? 1'b1 : rail_main_n;
      end else begin : g_no_mgmt
         logic unused_fw;
         assign unused_fw   = fw_present;
         assign rail_mgmt_n = rail_main_n;
      end
   endgenerate
endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
   import sleep_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_MGMT    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tgt_valid,
   input  logic [2:0] tgt_state,
   input  logic       wake_req,
   input  logic       overtemp_n,
   input  logic       force_off,
   input  logic       batt_weak,
   input  logic       vreg_good,
   input  logic       fw_present,
   output logic [2:0] sys_state,
   output logic       rail_main_n,
   output logic       rail_mem_n,
   output logic       rail_aux_n,
   output logic       rail_mgmt_n,
   output logic       deep_ind_n,
   output logic       suspending_n,
   output logic       clkgen_pg
);
   localparam int unsigned N_ASYNC = 4;
   localparam logic [N_ASYNC-1:0] ASYNC_RST = 4'b0100;

   logic [N_ASYNC-1:0] raw_in;
   logic [N_ASYNC-1:0] syn_in;
   logic               kill_s;

   assign raw_in = {batt_weak, overtemp_n, force_off, wake_req};

   sleep_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_ASYNC), .RST_VAL(ASYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign kill_s = !syn_in[2] || syn_in[1];

   sleep_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .tgt_valid(tgt_valid), .tgt_state(tgt_state),
      .wake_s(syn_in[0]), .kill_s(kill_s), .batt_s(syn_in[3]),
      .state_q(sys_state), .susp_n_q(suspending_n)
   );

   sleep_decode #(.HAS_MGMT(HAS_MGMT)) u_dec (
      .state_q(sys_state), .fw_present(fw_present), .vreg_good(vreg_good),
      .rail_main_n(rail_main_n), .rail_mem_n(rail_mem_n), .rail_aux_n(rail_aux_n),
      .rail_mgmt_n(rail_mgmt_n), .deep_ind_n(deep_ind_n), .clkgen_pg(clkgen_pg)
   );
endmodule

// File: rtl/sleep_state_ctrl_chk.sv
module sleep_state_ctrl_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       overtemp_n,
   input logic       force_off,
   input logic       vreg_good,
   input logic       fw_present,
   input logic [2:0] sys_state,
   input logic       rail_main_n,
   input logic       rail_mem_n,
   input logic       rail_aux_n,
   input logic       rail_mgmt_n,
   input logic       deep_ind_n,
   input logic       suspending_n,
   input logic       clkgen_pg
);
   localparam int unsigned LIM = SYNC_STAGES + 1;
   int unsigned trip_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trip_cnt <= 0;
      else if (overtemp_n && !force_off) trip_cnt <= 0;
      else if (trip_cnt < LIM) trip_cnt <= trip_cnt + 1;
   end

   p_mem_under_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_mem_n |-> !rail_main_n);
   p_aux_under_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_aux_n |-> (!rail_mem_n && sys_state == 3'd5));
   p_main_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_state == 3'd0 || sys_state == 3'd1) |-> rail_main_n);
   p_ind_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !deep_ind_n |-> (sys_state == 3'd4 || sys_state == 3'd5));
   p_kill_s5_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_cnt >= LIM && (!overtemp_n || force_off)) |-> sys_state == 3'd5);
   p_mgmt_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fw_present |-> rail_mgmt_n == rail_main_n);
   p_clkpg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clkgen_pg |-> (rail_main_n && vreg_good));
   p_susp_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_state != 3'd0) |-> !suspending_n);
   p_susp_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspending_n) |-> (sys_state == 3'd0 || sys_state == 3'd5));
endmodule

bind sleep_state_ctrl sleep_state_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .overtemp_n(overtemp_n), .force_off(force_off),
   .vreg_good(vreg_good), .fw_present(fw_present), .sys_state(sys_state),
   .rail_main_n(rail_main_n), .rail_mem_n(rail_mem_n), .rail_aux_n(rail_aux_n),
   .rail_mgmt_n(rail_mgmt_n), .deep_ind_n(deep_ind_n), .suspending_n(suspending_n),
   .clkgen_pg(clkgen_pg)
);

// File: tb/sleep_state_ctrl_test.sv
module sleep_state_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tgt_valid = 1'b0;
   logic [2:0] tgt_state = 3'd0;
   logic       wake_req = 1'b0;
   logic       overtemp_n = 1'b1;
   logic       force_off = 1'b0;
   logic       batt_weak = 1'b0;
   logic       vreg_good = 1'b1;
   logic       fw_present = 1'b0;
   logic [2:0] sys_state;
   logic       rail_main_n, rail_mem_n, rail_aux_n, rail_mgmt_n;
   logic       deep_ind_n, suspending_n, clkgen_pg;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      string      tag;
      logic [9:0] exp;
   } item_t;
   item_t sb_q[$];
   event  sb_ev;

   always #10 clk = ~clk;

   sleep_state_ctrl uut (.*);

   function automatic logic [9:0] model(input logic [2:0] st, input logic susp_n);
      logic main_n, s4g;
      main_n = !(st == 3'd3 || st == 3'd4 || st == 3'd5);
      s4g    = (st == 3'd4 || st == 3'd5);
      return {st, main_n, !s4g, (st != 3'd5), (fw_present ? 1'b1 : main_n),
              !s4g, susp_n, (main_n && vreg_good)};
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_now(input string tag, input logic [2:0] st, input logic susp_n);
      item_t it;
      it.tag = tag;
      it.exp = model(st, susp_n);
      sb_q.push_back(it);
      -> sb_ev;
      #1;
   endtask

   initial begin : monitor
      forever begin
         @(sb_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it  = sb_q.pop_front();
            act = {sys_state, rail_main_n, rail_mem_n, rail_aux_n, rail_mgmt_n,
                   deep_ind_n, suspending_n, clkgen_pg};
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic request(input logic [2:0] code);
      tgt_valid = 1'b1; tgt_state = code;
      cyc(1);
      tgt_valid = 1'b0;
   endtask

   task automatic wake();
      wake_req = 1'b1;
      cyc(1);
      wake_req = 1'b0;
      cyc(4);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      expect_now("reset R1 R2 R3 R4 R9", 3'd0, 1'b1);
      vreg_good = 1'b0; #1;
      expect_now("R9 regulator low", 3'd0, 1'b1);
      vreg_good = 1'b1;
      // accept S3: status low one edge before state
      request(3'd3);
      expect_now("R10 status leads", 3'd0, 1'b0);
      cyc(1);
      expect_now("R1 R7 in S3", 3'd3, 1'b0);
      fw_present = 1'b1; #1;
      expect_now("R7 firmware holds mgmt", 3'd3, 1'b0);
      fw_present = 1'b0;
      request(3'd1); cyc(3);
      expect_now("R12 request outside S0", 3'd3, 1'b0);
      batt_weak = 1'b1; cyc(3);
      wake();
      expect_now("R8 blocked from S3", 3'd3, 1'b0);
      batt_weak = 1'b0; cyc(3);
      wake();
      expect_now("R11 wake from S3", 3'd0, 1'b1);
      request(3'd1); cyc(1);
      expect_now("R11 in S1", 3'd1, 1'b0);
      batt_weak = 1'b1; cyc(3);
      wake();
      expect_now("R8 S1 wake allowed", 3'd0, 1'b1);
      batt_weak = 1'b0; cyc(3);
      request(3'd2); cyc(3);
      expect_now("R12 illegal code", 3'd0, 1'b1);
      request(3'd4); cyc(1);
      expect_now("R2 R4 in S4", 3'd4, 1'b0);
      wake();
      expect_now("R11 wake from S4", 3'd0, 1'b1);
      request(3'd5); cyc(1);
      expect_now("R3 in S5", 3'd5, 1'b0);
      wake();
      expect_now("R11 wake from S5", 3'd0, 1'b1);
      // trip and wake on the same edge while in S3
      request(3'd3); cyc(1);
      overtemp_n = 1'b0; wake_req = 1'b1;
      cyc(1); wake_req = 1'b0;
      cyc(3);
      expect_now("R5 trip beats wake", 3'd5, 1'b0);
      wake();
      expect_now("R5 trip held", 3'd5, 1'b0);
      overtemp_n = 1'b1; cyc(3);
      wake();
      expect_now("R11 after trip", 3'd0, 1'b1);
      request(3'd1); cyc(1);
      force_off = 1'b1; cyc(4);
      expect_now("R6 forced off from S1", 3'd5, 1'b0);
      force_off = 1'b0; cyc(3);
      wake();
      expect_now("R11 after forced off", 3'd0, 1'b1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule